// File: doc/BRIEF.md
# Dual-Preset Sampling Time Controller

This block times one conversion at a time for a converter controller. Two shared 3-bit sampling presets serve every channel. A bitmap with one bit per channel chooses, for each channel, which preset sets its sampling length. A start request names a channel. The controller then drives the sample switch for the selected length, raises a sticky end-of-sampling flag, runs a fixed conversion phase of 12.5 converter clocks, and emits a one-cycle done pulse.

All durations are counted in half converter-clock steps. The caller supplies a tick enable at twice the converter rate. Preset codes 0 to 7 give 1.5, 3.5, 7.5, 12.5, 19.5, 39.5, 79.5 and 160.5 cycles of sampling, so the shortest whole conversion lasts 14 converter cycles. The sequencer, the analog front end and result capture sit outside this block.

Top module: `stc_sample_timer`

## Requirements
- R1: Preset codes 0,1,2,3,4,5,6,7 hold `sample_en` high for 3,7,15,25,39,79,159,321 half-cycle ticks.
- R2: `preset_pick[chan]` = 0 selects `preset_a` for the sampling phase, and 1 selects `preset_b`.
- R3: When sampling ends, `busy` stays high with `sample_en` low for exactly 25 more ticks (12.5 cycles). `sample_en` is never high unless `busy` is high.
- R4: `done` is high for one clock on the edge that ends the conversion phase. `busy` is low in that same cycle.
- R5: `eos_flag` rises on the edge where `sample_en` falls. It then stays high until it is cleared.
- R6: `eos_clr` = 1 clears `eos_flag` on the next edge. If a clear and the end of sampling fall on the same edge, the flag ends up set.
- R7: A `start` that arrives while `busy` is high is ignored and does not change the running conversion.
- R8: The sampling length is fixed at the accepted start. Changes to the presets or the bitmap during a conversion have no effect on it.
- R9: Both phase counters advance only on clocks where `half_tick` is 1. `sample_en` and `busy` hold their values while `busy` is high and `half_tick` is 0.
- R10: After synchronous reset `sample_en`, `busy`, `done` and `eos_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | Enable at twice the converter clock rate |
| start | input | 1 | Request a conversion for `chan` |
| chan | input | 4 | Channel of the request |
| preset_a | input | 3 | First shared sampling preset code |
| preset_b | input | 3 | Second shared sampling preset code |
| preset_pick | input | 16 | Per-channel preset select bitmap |
| eos_clr | input | 1 | Write-one-to-clear for `eos_flag` |
| sample_en | output | 1 | Sample switch drive |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |
| eos_flag | output | 1 | Sticky end-of-sampling flag |

## Verification
The end-of-sampling set and the write-one-to-clear can land on the same edge. The bench forces this by holding `eos_clr` high for the whole sampling phase. The flag must stay 0 throughout that phase and read 1 once `sample_en` drops. A second overlap is a fresh `start` during the conversion phase. It is judged by the tick counts of the running conversion, which must stay unchanged, and by `busy` and `sample_en` staying low after `done`. Every preset code is swept through both select values, with expected tick counts worked out arithmetically from the cycle values.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned CONV_HT  = 25;

  typedef enum logic [1:0] {ST_IDLE, ST_SAMP, ST_CONV} stc_state_e;

  // sampling length in half-cycle ticks: 2 * (whole cycles) + 1
  function automatic int unsigned code_halfticks(input logic [CODE_W-1:0] code);
    int unsigned whole;
    case (code)
      3'd0: whole = 1;
      3'd1: whole = 3;
      3'd2: whole = 7;
      3'd3: whole = 12;
      3'd4: whole = 19;
      3'd5: whole = 39;
      3'd6: whole = 79;
      default: whole = 160;
    endcase
    return 2 * whole + 1;
  endfunction
endpackage

// File: rtl/stc_preset_mux.sv
module stc_preset_mux
  import stc_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int CNT_W = 9,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [CH_W-1:0]   chan,
  input  logic [CODE_W-1:0] preset_a,
  input  logic [CODE_W-1:0] preset_b,
  input  logic [NCH-1:0]    preset_pick,
  output logic [CNT_W-1:0]  samp_len
);
  logic [CODE_W-1:0] code_sel;
  int unsigned       ht;

  always_comb begin
    code_sel = preset_pick[chan] ? preset_b : preset_a;
    ht       = code_halfticks(code_sel);
    samp_len = ht[CNT_W-1:0];
  end
endmodule

// File: rtl/stc_phase_timer.sv
module stc_phase_timer
  import stc_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_tick,
  input  logic             start,
  input  logic [CNT_W-1:0] samp_len,
  output logic             sample_en,
  output logic             busy,
  output logic             done,
  output logic             samp_end
);
  localparam logic [CNT_W-1:0] CONV_LEN = CNT_W'(CONV_HT);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  stc_state_e       state;
  logic [CNT_W-1:0] cnt;

  assign samp_end = (state == ST_SAMP) && half_tick && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sample_en <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_SAMP;
            cnt       <= samp_len;
            sample_en <= 1'b1;
            busy      <= 1'b1;
          end
        end
        ST_SAMP: begin
          if (half_tick) begin
            if (cnt == ONE) begin
              state     <= ST_CONV;
              cnt       <= CONV_LEN;
              sample_en <= 1'b0;
            end else begin
              cnt <= cnt - ONE;
            end
          end
        end
        ST_CONV: begin
          if (half_tick) begin
            if (cnt == ONE) begin
              state <= ST_IDLE;
              cnt   <= '0;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              cnt <= cnt - ONE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stc_eos_flag.sv
module stc_eos_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)        flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end
endmodule

// File: rtl/stc_sample_timer.sv
module stc_sample_timer
  import stc_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int CNT_W = 9,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_tick,
  input  logic              start,
  input  logic [CH_W-1:0]   chan,
  input  logic [CODE_W-1:0] preset_a,
  input  logic [CODE_W-1:0] preset_b,
  input  logic [NCH-1:0]    preset_pick,
  input  logic              eos_clr,
  output logic              sample_en,
  output logic              busy,
  output logic              done,
  output logic              eos_flag
);
  logic [CNT_W-1:0] samp_len;
  logic             samp_end;
  logic             start_ok;

  assign start_ok = start && !busy;

  stc_preset_mux #(.NCH(NCH), .CNT_W(CNT_W)) u_mux (
    .chan(chan), .preset_a(preset_a), .preset_b(preset_b),
    .preset_pick(preset_pick), .samp_len(samp_len)
  );

  stc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .half_tick(half_tick), .start(start_ok),
    .samp_len(samp_len), .sample_en(sample_en), .busy(busy),
    .done(done), .samp_end(samp_end)
  );

  stc_eos_flag u_eos (
    .clk(clk), .rst(rst), .set_i(samp_end), .clr_i(eos_clr), .flag(eos_flag)
  );
endmodule

// File: rtl/stc_sample_timer_chk.sv
module stc_sample_timer_chk (
  input logic clk,
  input logic rst,
  input logic half_tick,
  input logic start,
  input logic eos_clr,
  input logic sample_en,
  input logic busy,
  input logic done,
  input logic eos_flag
);
  p_samp_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> busy);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_busy_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_eos_set_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(sample_en) |-> eos_flag);

  p_eos_clr_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(eos_clr) && !$fell(sample_en)) |-> !eos_flag);

  p_start_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_en) |-> ($past(start) && !$past(busy)));

  p_tick_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !half_tick) |=> ($stable(sample_en) && $stable(busy)));
endmodule

bind stc_sample_timer stc_sample_timer_chk u_chk (
  .clk(clk), .rst(rst), .half_tick(half_tick), .start(start),
  .eos_clr(eos_clr), .sample_en(sample_en), .busy(busy),
  .done(done), .eos_flag(eos_flag)
);

// File: tb/sim_stc_sample_timer.sv
module sim_stc_sample_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        half_tick = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  chan = '0;
  logic [2:0]  preset_a = '0;
  logic [2:0]  preset_b = '0;
  logic [15:0] preset_pick = '0;
  logic        eos_clr = 1'b0;
  logic        sample_en, busy, done, eos_flag;

  int vectors = 0;
  int fails   = 0;
  int tick_mode = 0;

  always #10 clk = ~clk;

  stc_sample_timer u0 (
    .clk(clk), .rst(rst), .half_tick(half_tick), .start(start), .chan(chan),
    .preset_a(preset_a), .preset_b(preset_b), .preset_pick(preset_pick),
    .eos_clr(eos_clr), .sample_en(sample_en), .busy(busy), .done(done),
    .eos_flag(eos_flag)
  );

  function automatic int exp_ht(input int code);
    int whole [8] = '{1, 3, 7, 12, 19, 39, 79, 160};
    return 2 * whole[code] + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_tick();
    if (tick_mode == 0) half_tick = 1'b1;
    else                half_tick = ~half_tick;
  endtask

  // one conversion; clr_hold: eos_clr held during sampling, disturb: change presets,
  // restart: extra start during conversion phase
  task automatic run_conv(input int ch, input int exp_s, input string req,
                          input bit clr_hold, input bit disturb, input bit restart);
    int sc = 0, cc = 0, guard = 0;
    bit seen_done = 0, first = 1, flag_checked = 0;
    @(negedge clk);
    chan = 4'(ch); start = 1'b1; eos_clr = 1'b1;
    drive_tick();
    @(negedge clk);
    start = 1'b0; eos_clr = 1'b0;
    forever begin
      if (first) begin
        chk(eos_flag == 1'b0, "R5", eos_flag, 0);
        chk(sample_en == 1'b1 && busy == 1'b1, "R3", sample_en, 1);
        first = 0;
        if (disturb) begin preset_a = ~preset_a; preset_b = ~preset_b; preset_pick = ~preset_pick; end
      end
      if (done) begin seen_done = 1; break; end
      if (!sample_en && !flag_checked) begin
        chk(eos_flag == 1'b1, clr_hold ? "R6" : "R5", eos_flag, 1);
        flag_checked = 1;
      end
      if (clr_hold && sample_en && sc > 0) chk(eos_flag == 1'b0, "R6", eos_flag, 0);
      eos_clr = clr_hold && sample_en;
      start = restart && !sample_en && cc == 10;
      if (start) chan = 4'(ch ^ 4'h5);
      drive_tick();
      if (sample_en && half_tick) sc++;
      if (busy && !sample_en && half_tick) cc++;
      guard++;
      if (guard > 3000) break;
      @(negedge clk);
    end
    eos_clr = 1'b0; start = 1'b0;
    chk(seen_done, "R4", seen_done, 1);
    chk(sc == exp_s, req, sc, exp_s);
    chk(cc == 25, "R3", cc, 25);
    chk(busy == 1'b0, "R4", busy, 0);
    drive_tick();
    @(negedge clk);
    chk(done == 1'b0, "R4", done, 0);
    chk(busy == 1'b0 && sample_en == 1'b0, "R7", busy, 0);
    chk(eos_flag == 1'b1, "R5", eos_flag, 1);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    start = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sample_en && !busy && !done && !eos_flag, "R10", {sample_en, busy, done, eos_flag}, 0);
    rst = 1'b0; start = 1'b0;
    @(negedge clk);
    chk(!busy, "R10", busy, 0);

    // R1/R2 sweep: every code through both presets
    for (int code = 0; code < 8; code++) begin
      for (int sel = 0; sel < 2; sel++) begin
        int ch = (code * 3 + sel * 5) % 16;
        preset_pick = 16'hA5C3 ^ 16'(code * 16'h1111);
        preset_pick[ch] = sel[0];
        if (sel == 0) begin preset_a = 3'(code); preset_b = 3'(7 - code); end
        else          begin preset_b = 3'(code); preset_a = 3'(7 - code); end
        run_conv(ch, exp_ht(code), sel ? "R2" : "R1", 0, 0, 0);
      end
    end

    // R9: half-rate ticks
    tick_mode = 1;
    for (int code = 0; code < 8; code += 3) begin
      preset_a = 3'(code); preset_pick = '0;
      run_conv(2, exp_ht(code), "R9", 0, 0, 0);
    end
    tick_mode = 0;

    // R6: clear colliding with end of sampling
    preset_a = 3'd1; preset_pick = '0;
    run_conv(4, exp_ht(1), "R6", 1, 0, 0);

    // R8: presets and bitmap change mid-conversion
    preset_a = 3'd2; preset_b = 3'd6; preset_pick = 16'h0000;
    run_conv(9, exp_ht(2), "R8", 0, 1, 0);

    // R7: extra start during the conversion phase
    preset_a = 3'd3; preset_b = 3'd7; preset_pick = 16'h0000;
    run_conv(1, exp_ht(3), "R7", 0, 0, 1);

    // R6: plain clear of a set flag
    @(negedge clk); eos_clr = 1'b1;
    @(negedge clk); eos_clr = 1'b0;
    chk(eos_flag == 1'b0, "R6", eos_flag, 0);
    repeat (4) @(negedge clk);
    chk(eos_flag == 1'b0 && !busy, "R6", eos_flag, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule